// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This block produces a counted train of configuration clock pulses under register control. A host writes a pulse count to one register, and that write starts the burst. The block then drives its clock output high for one local clock cycle and low for the next, once per requested pulse. When the last pulse has ended, it sets a sticky completion flag. The host polls the flag through a second register and clears it by writing a one to it. Software normally clears the flag before it issues a burst and again after the burst has finished.

The host side is a plain 32-bit register port with separate write and read strobes and a byte offset. The pulse counter width is a parameter. The default of 16 bits covers the long bursts a configuration sequence needs, such as 256 or 2047 pulses. While a burst runs, reading the count register returns how many pulses are still to come. A new count written during a burst replaces the remaining count and restarts the sequence from that value.

Top module: `cfg_clk_burst`

## Requirements
- R1: After reset, `cfgClk` is low, the count register reads 0 and the status register reads 0.
- R2: A write to byte offset 0x08 starts a burst of exactly N pulses on `cfgClk`, where N is the low `CNT_W` bits of the write data. The upper data bits are ignored.
- R3: Each pulse is high for one `clk` cycle and then low for one `clk` cycle. The first high cycle follows the clock edge that accepts the count write, so `cfgClk` is high in the odd cycles 1, 3, ..., 2N-1 counted from that edge.
- R4: A read at offset 0x08 returns the number of pulses not yet completed, zero-extended to 32 bits. This value falls by one at the end of each pulse's low cycle.
- R5: Bit 0 of the register at offset 0x0C is the done flag. It is set at the edge that ends the low cycle of the last pulse and then stays set. Status bits 31:1 read as 0.
- R6: Writing offset 0x0C with data bit 0 set clears the done flag. Writing it with bit 0 clear leaves the flag unchanged.
- R7: Writing a count of 0 emits no pulses and sets the done flag at the accepting edge.
- R8: A count write during a running burst drives `cfgClk` low, replaces the remaining count with the new value and clears done. Exactly the new number of pulses follow, and done stays clear until they finish.
- R9: Reads at any offset other than 0x08 and 0x0C return 0. Writes to other offsets change neither the count, nor the done flag, nor `cfgClk`. When `rdEn` is low, `rdData` is 0.
- R10: If a clear write reaches the status register on the same edge as the completion of the last pulse, the done flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one transfer per cycle it is high |
| rdEn | input | 1 | Read strobe; `rdData` is valid in the same cycle |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` and state |
| cfgClk | output | 1 | Configuration clock pulse output |

## Verification
The situation hardest to reach from the ports is a status clear that lands on the exact edge where the final pulse completes, because that cycle lies 2N cycles after the count write. The stimulus reaches it by following a directed burst cycle by cycle and issuing the clear write in the high cycle of the last pulse, so the write is accepted on the completing edge. Reloads in the middle of a burst are also placed at random points, in both high and low phases, so that the restart from an arbitrary phase is exercised against the expected pulse train.

// File: rtl/cfg_burst_pkg.sv
package cfg_burst_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned OFS_COUNT  = 32'h08;
  localparam int unsigned OFS_STATUS = 32'h0C;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic load;       // count write accepted
    logic clearDone;  // write-one to done flag
    logic rise;       // drive pulse high this edge
    logic fall;       // drive pulse low and retire one pulse
  } burstStrobe_t;

  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } phase_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import cfg_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit0,
  input  logic              busy,
  output burstStrobe_t      strb
);

  localparam logic [ADDR_W-1:0] CountOfs  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] StatusOfs = ADDR_W'(OFS_STATUS);

  phase_e phase;
  logic   hitCount;
  logic   hitStatus;

  always_comb begin
    hitCount       = (addr == CountOfs);
    hitStatus      = (addr == StatusOfs);
    strb.load      = wrEn && hitCount;
    strb.clearDone = wrEn && hitStatus && wrBit0;
    strb.rise      = !strb.load && busy && (phase == PH_RISE);
    strb.fall      = !strb.load && busy && (phase == PH_FALL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_RISE;
    end else if (strb.load) begin
      phase <= PH_RISE;
    end else if (strb.rise) begin
      phase <= PH_FALL;
    end else if (strb.fall) begin
      phase <= PH_RISE;
    end
  end

  // R3: a high cycle is always followed by a low one (or a reload)
  a_r3_fall_follows_rise: assert property (@(posedge clk) disable iff (!rstN)
    strb.rise |=> (strb.fall || strb.load));

  // R3: never both edges in one cycle
  a_r3_single_edge: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rise, strb.fall}));

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import cfg_burst_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobe_t      strb,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              cfgClk,
  output logic [REG_W-1:0]  rdData
);

  localparam logic [ADDR_W-1:0] CountOfs  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] StatusOfs = ADDR_W'(OFS_STATUS);
  localparam logic [CNT_W-1:0]  One       = CNT_W'(1);

  logic [CNT_W-1:0] remain;
  logic             done;
  logic             cfgClkQ;
  logic             lastFall;

  assign busy     = (remain != '0);
  assign lastFall = strb.fall && (remain == One);
  assign cfgClk   = cfgClkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain  <= '0;
      done    <= 1'b0;
      cfgClkQ <= 1'b0;
    end else if (strb.load) begin
      remain  <= loadVal;
      cfgClkQ <= 1'b0;
      done    <= (loadVal == '0);
    end else begin
      if (strb.rise) begin
        cfgClkQ <= 1'b1;
      end
      if (strb.fall) begin
        cfgClkQ <= 1'b0;
        remain  <= remain - One;
      end
      if (lastFall) begin
        done <= 1'b1;
      end else if (strb.clearDone) begin
        done <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == CountOfs) begin
        rdData = REG_W'(remain);
      end else if (addr == StatusOfs) begin
        rdData[0] = done;
      end
    end
  end

  a_r3_high_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cfgClkQ |=> !cfgClkQ);

  a_r2_rise_needs_work: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClkQ) |-> ($past(remain) != '0));

  a_r4_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> (remain <= $past(remain)));

  a_r5_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (remain == '0));

  a_r7_zero_load: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && (loadVal == '0)) |=> (done && !cfgClkQ));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    lastFall |=> done);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearDone && !lastFall) |=> !done);

endmodule

// File: rtl/cfg_clk_burst.sv
module cfg_clk_burst
  import cfg_burst_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              cfgClk
);

  burstStrobe_t strb;
  logic         busy;
  logic         wrDataUnused;

  // upper data bits carry no meaning for either register
  assign wrDataUnused = ^wrData;

  burst_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrBit0 (wrData[0]),
    .busy   (busy),
    .strb   (strb)
  );

  burst_datapath #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .loadVal (wrData[CNT_W-1:0]),
    .rdEn    (rdEn),
    .addr    (addr),
    .busy    (busy),
    .cfgClk  (cfgClk),
    .rdData  (rdData)
  );

endmodule

// File: tb/cfg_clk_burst_tb.sv
module cfg_clk_burst_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam logic [7:0] A_CNT  = 8'h08;
  localparam logic [7:0] A_STAT = 8'h0C;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic        rdEn;
  logic [7:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        cfgClk;

  int nChecks = 0;
  int nFail   = 0;
  bit ended   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_clk_burst #(.CNT_W(CNT_W), .ADDR_W(8)) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .cfgClk (cfgClk)
  );

  // expected values, k = negedges since the accepting edge
  function automatic logic expClk(int n, int k);
    return (k >= 1) && (k <= 2*n) && (k % 2 == 1);
  endfunction

  function automatic int expRemain(int n, int k);
    return (k >= 2*n) ? 0 : n - k/2;
  endfunction

  function automatic logic expDone(int n, int k);
    return k >= 2*n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    rdEn   = 1'b0;
    wrEn   = 1'b1;
    addr   = a;
    wrData = d;
    @(negedge clk);
    wrEn   = 1'b0;
    wrData = '0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string req);
    rdEn = 1'b1;
    addr = a;
    #1;
    chk(rdData === exp, req, rdData, exp);
    rdEn = 1'b0;
  endtask

  // follow a burst of n pulses for the given number of negedges
  task automatic watch(input int n, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      int sel;
      sel  = int'($urandom % 3);
      rdEn = 1'b1;
      addr = (sel == 0) ? A_CNT : (sel == 1) ? A_STAT : 8'h04;
      #1;
      chk(cfgClk === expClk(n, k), "R3", {31'b0, cfgClk}, {31'b0, expClk(n, k)});
      if (sel == 0)
        chk(rdData === 32'(expRemain(n, k)), "R4", rdData, 32'(expRemain(n, k)));
      else if (sel == 1)
        chk(rdData === {31'b0, expDone(n, k)}, "R5", rdData, {31'b0, expDone(n, k)});
      else
        chk(rdData === 32'h0, "R9", rdData, 32'h0);
      @(negedge clk);
    end
    rdEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL R2 watchdog expired act=%0d exp=0", nChecks);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(cfgClk === 1'b0, "R1", {31'b0, cfgClk}, 32'h0);
    rdChk(A_CNT, 32'h0, "R1");
    rdChk(A_STAT, 32'h0, "R1");
    @(negedge clk);

    // R2 basic burst
    wr(A_STAT, 32'h1);
    wr(A_CNT, 32'd5);
    watch(5, 13);

    // R6 write-one-to-clear, zero write leaves flag
    wr(A_STAT, 32'h0);
    rdChk(A_STAT, 32'h1, "R6");
    wr(A_STAT, 32'hFFFF_FFFE);
    rdChk(A_STAT, 32'h1, "R6");
    wr(A_STAT, 32'h1);
    rdChk(A_STAT, 32'h0, "R6");

    // R9 writes elsewhere ignored, reads elsewhere zero
    wr(8'h00, 32'd9);
    wr(8'h10, 32'd9);
    for (int k = 0; k < 4; k++) begin
      chk(cfgClk === 1'b0, "R9", {31'b0, cfgClk}, 32'h0);
      rdChk(A_CNT, 32'h0, "R9");
      rdChk(A_STAT, 32'h0, "R9");
      @(negedge clk);
    end
    rdChk(8'h04, 32'h0, "R9");
    rdChk(8'h80, 32'h0, "R9");

    // R7 zero count
    wr(A_CNT, 32'd0);
    watch(0, 4);

    // R2 upper data bits ignored
    wr(A_STAT, 32'h1);
    wr(A_CNT, 32'hABCD_0003);
    watch(3, 9);

    // R8 reload mid-burst, in low phase then high phase, then to zero
    wr(A_STAT, 32'h1);
    wr(A_CNT, 32'd6);
    watch(6, 4);
    wr(A_CNT, 32'd2);
    watch(2, 6);
    wr(A_CNT, 32'd4);
    watch(4, 5);
    wr(A_CNT, 32'd3);
    watch(3, 8);
    wr(A_STAT, 32'h1);
    wr(A_CNT, 32'd7);
    watch(7, 3);
    wr(A_CNT, 32'd0);
    watch(0, 3);

    // R10 clear lands on completing edge: done must remain set
    wr(A_STAT, 32'h1);
    wr(A_CNT, 32'd3);
    watch(3, 5);
    wr(A_STAT, 32'h1);
    chk(cfgClk === 1'b0, "R10", {31'b0, cfgClk}, 32'h0);
    rdChk(A_STAT, 32'h1, "R10");
    rdChk(A_CNT, 32'h0, "R10");
    @(negedge clk);
    wr(A_STAT, 32'h1);
    rdChk(A_STAT, 32'h0, "R10");
    @(negedge clk);

    // R2 long bursts
    wr(A_STAT, 32'h1);
    wr(A_CNT, 32'd256);
    watch(256, 515);
    wr(A_STAT, 32'h1);
    wr(A_CNT, 32'h7FF);
    watch(2047, 4097);

    // random bursts with random reloads
    for (int it = 0; it < 40; it++) begin
      int n;
      n = int'($urandom_range(0, 24));
      if ($urandom % 2 == 0) wr(A_STAT, 32'h1);
      wr(A_CNT, 32'(n));
      if ((n > 0) && ($urandom % 3 == 0)) begin
        int m;
        int n2;
        m  = int'($urandom_range(1, 2*n - 1));
        watch(n, m);
        n2 = int'($urandom_range(0, 10));
        wr(A_CNT, 32'(n2));
        watch(n2, 2*n2 + 3);
      end else begin
        watch(n, 2*n + 3);
      end
    end

    summary();
  end

endmodule